// File: doc/BRIEF.md
# Test Access Port Controller with Fabric-Side User Scan Port

This block is a serial test access port controller. Its sixteen-state sequencer advances on the rising edge of the test clock, steered by the mode-select line. It contains an 8-bit instruction register and a one-bit bypass register, and it multiplexes the serial data output. The controller also exposes its internal state to the surrounding design, so that user logic can implement its own data registers behind the same port.

Toward the fabric, the block drives several signals:
- the active instruction code;
- an active-low flag that is low while the sequencer rests in its reset state;
- a copy of the effective serial input and of the test clock;
- three single-cycle strobes that mark the capture, shift and update data-register states.

When the active instruction falls in the user range, the serial output is taken from a fabric-supplied bit. Every other code selects the internal bypass register.

An override select allows on-chip logic to replace both the external serial input and the external active-low test reset. When the select is low, the external pins are used. It should be tied low when the override is not wanted.

Top module: `user_tap`

## Requirements
- R1: `usr_ir` always shows the 8-bit active instruction. The active instruction becomes 8'hFF on any rising edge where the sequencer is in its reset state or where reset is applied.
- R2: In the capture-instruction state the instruction shift stage loads 8'h01. In shift-instruction it shifts toward bit 0, taking the new bit into bit 7, and `tdo` shows bit 0. The active instruction takes the shifted value only on the rising edge taken from update-instruction.
- R3: While the active instruction lies in the range 16 to 127 inclusive, `tdo` in shift-data carries `usr_tdo`, sampled at the falling edge.
- R4: Any instruction outside 16 to 127 selects the bypass bit. That bit loads 0 in capture-data, then takes the effective serial input on each shift-data rising edge, and `tdo` carries it.
- R5: `usr_rst_n` is 0 exactly while the sequencer is in its reset state.
- R6: `usr_capture`, `usr_shift` and `usr_update` are each 1 only in capture-data, shift-data and update-data respectively. At most one of them is high at a time.
- R7: The sequencer follows the standard sixteen-state test-port transition graph on rising `tck`. Five rising edges with `tms` high reach the reset state from any state; four are not enough from shift-data.
- R8: A low effective test reset, or a high `por`, puts the sequencer into its reset state on the next rising edge, whatever `tms` is.
- R9: With `sec_en` high, `sec_tdi` and `sec_trst_n` act as the effective serial input and test reset, and the external `tdi` and `trst_n` have no effect. With `sec_en` low, the external pins act.
- R10: `usr_tdi` equals the effective serial input at all times, and `usr_tck` equals `tck`.
- R11: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is 1 only after a falling edge taken in shift-instruction or shift-data. Whenever `tdo_oe` is 0, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, synchronous to `tck` |
| tms | input | 1 | Mode select steering the sequencer |
| tdi | input | 1 | External serial data input |
| trst_n | input | 1 | External test reset, active low |
| tdo | output | 1 | Serial data output |
| tdo_oe | output | 1 | Output enable for `tdo` (high-impedance when 0) |
| sec_en | input | 1 | Override select for serial input and test reset |
| sec_tdi | input | 1 | Serial input used when the override is selected |
| sec_trst_n | input | 1 | Active-low test reset used when the override is selected |
| usr_ir | output | 8 | Active instruction code |
| usr_rst_n | output | 1 | Low while the sequencer is in its reset state |
| usr_tdi | output | 1 | Effective serial input |
| usr_tck | output | 1 | Copy of the test clock |
| usr_tdo | input | 1 | Fabric data bit shifted out under user instructions |
| usr_capture | output | 1 | High in capture-data |
| usr_shift | output | 1 | High in shift-data |
| usr_update | output | 1 | High in update-data |

## Verification
The bench builds the block with its default parameters: an 8-bit instruction, a user range of 16 to 127, a capture pattern of 8'h01 and a reset code of all ones. With 8 bits, every instruction needs exactly eight shift steps, so codes on both sides of each user-range boundary (15, 16, 127 and 128) can be loaded and told apart by the first bit shifted out of the data path. These values also keep the captured pattern and the reset code distinct from every boundary code. That makes an early or a missing instruction update visible on `usr_ir`.

// File: rtl/user_tap_pkg.sv
`timescale 1ns/1ps
package user_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SH, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SH, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: return m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: return m ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_SH:  return m ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_EX1: return m ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: return m ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: return m ? ST_DR_UPD : ST_DR_SH;
      ST_DR_UPD: return m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: return m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: return m ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_SH:  return m ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_EX1: return m ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: return m ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: return m ? ST_IR_UPD : ST_IR_SH;
      ST_IR_UPD: return m ? ST_DR_SEL : ST_IDLE;
      default:   return ST_RESET;
    endcase
  endfunction

endpackage

// File: rtl/user_tap_fsm.sv
`timescale 1ns/1ps
module user_tap_fsm
  import user_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

endmodule

// File: rtl/user_tap_ir.sv
`timescale 1ns/1ps
module user_tap_ir
  import user_tap_pkg::*;
#(
  parameter int              IR_W      = 8,
  parameter logic [IR_W-1:0] CAPT_CODE = {{(IR_W-1){1'b0}}, 1'b1},
  parameter logic [IR_W-1:0] RST_CODE  = '1
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] shreg;

  always_ff @(posedge tck) begin
    if (rst || state == ST_RESET) begin
      shreg <= RST_CODE;
      ir_q  <= RST_CODE;
    end else begin
      case (state)
        ST_IR_CAP: shreg <= CAPT_CODE;
        ST_IR_SH:  shreg <= {tdi, shreg[IR_W-1:1]};
        ST_IR_UPD: ir_q  <= shreg;
        default: ;
      endcase
    end
  end

  assign ir_lsb = shreg[0];

endmodule

// File: rtl/user_tap_dout.sv
`timescale 1ns/1ps
module user_tap_dout
  import user_tap_pkg::*;
#(
  parameter int IR_W    = 8,
  parameter int USER_LO = 16,
  parameter int USER_HI = 127
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir_q,
  input  logic            ir_lsb,
  input  logic            tdi,
  input  logic            usr_tdo,
  output logic            tdo,
  output logic            tdo_oe
);

  localparam logic [IR_W-1:0] LO_CODE = IR_W'(USER_LO);
  localparam logic [IR_W-1:0] HI_CODE = IR_W'(USER_HI);

  logic user_sel;
  logic byp;

  assign user_sel = (ir_q >= LO_CODE) && (ir_q <= HI_CODE);

  // single-bit bypass path, rising edge
  always_ff @(posedge tck) begin
    if (rst)                                byp <= 1'b0;
    else if (state == ST_DR_CAP && !user_sel) byp <= 1'b0;
    else if (state == ST_DR_SH  && !user_sel) byp <= tdi;
  end

  // output stage retimed to the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo_oe <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      case (state)
        ST_IR_SH: begin tdo_oe <= 1'b1; tdo <= ir_lsb; end
        ST_DR_SH: begin tdo_oe <= 1'b1; tdo <= user_sel ? usr_tdo : byp; end
        default:  begin tdo_oe <= 1'b0; tdo <= 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/user_tap.sv
`timescale 1ns/1ps
module user_tap
  import user_tap_pkg::*;
#(
  parameter int IR_W    = 8,
  parameter int USER_LO = 16,
  parameter int USER_HI = 127
) (
  input  logic            tck,
  input  logic            por,
  input  logic            tms,
  input  logic            tdi,
  input  logic            trst_n,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic            sec_en,
  input  logic            sec_tdi,
  input  logic            sec_trst_n,
  output logic [IR_W-1:0] usr_ir,
  output logic            usr_rst_n,
  output logic            usr_tdi,
  output logic            usr_tck,
  input  logic            usr_tdo,
  output logic            usr_capture,
  output logic            usr_shift,
  output logic            usr_update
);

  localparam logic [IR_W-1:0] CAPT_CODE = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] RST_CODE  = '1;

  logic       eff_tdi, eff_trst_n, rst;
  logic       ir_lsb;
  tap_state_e state;
  logic [IR_W-1:0] ir_q;

  assign eff_tdi    = sec_en ? sec_tdi    : tdi;
  assign eff_trst_n = sec_en ? sec_trst_n : trst_n;
  assign rst        = por | ~eff_trst_n;

  user_tap_fsm u_fsm (
    .tck(tck), .rst(rst), .tms(tms), .state(state)
  );

  user_tap_ir #(.IR_W(IR_W), .CAPT_CODE(CAPT_CODE), .RST_CODE(RST_CODE)) u_ir (
    .tck(tck), .rst(rst), .state(state), .tdi(eff_tdi), .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  user_tap_dout #(.IR_W(IR_W), .USER_LO(USER_LO), .USER_HI(USER_HI)) u_dout (
    .tck(tck), .rst(rst), .state(state), .ir_q(ir_q), .ir_lsb(ir_lsb),
    .tdi(eff_tdi), .usr_tdo(usr_tdo), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign usr_ir      = ir_q;
  assign usr_rst_n   = (state != ST_RESET);
  assign usr_tdi     = eff_tdi;
  assign usr_tck     = tck;
  assign usr_capture = (state == ST_DR_CAP);
  assign usr_shift   = (state == ST_DR_SH);
  assign usr_update  = (state == ST_DR_UPD);

endmodule

// File: rtl/user_tap_chk.sv
`timescale 1ns/1ps
module user_tap_chk #(
  parameter int IR_W = 8
) (
  input logic            tck,
  input logic            por,
  input logic            tms,
  input logic            trst_n,
  input logic            sec_en,
  input logic            sec_trst_n,
  input logic [IR_W-1:0] usr_ir,
  input logic            usr_rst_n,
  input logic            usr_capture,
  input logic            usr_shift,
  input logic            usr_update,
  input logic            tdo_oe
);

  logic trst_eff_n;
  assign trst_eff_n = sec_en ? sec_trst_n : trst_n;

  // R6
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (por)
    $onehot0({usr_capture, usr_shift, usr_update}));

  // R5
  reset_hold_chk: assert property (@(posedge tck) disable iff (por)
    (!usr_rst_n && tms) |=> !usr_rst_n);

  // R8
  trst_force_chk: assert property (@(posedge tck) disable iff (por)
    !trst_eff_n |=> !usr_rst_n);

  // R7
  capture_to_shift_chk: assert property (@(posedge tck) disable iff (por)
    (usr_capture && !tms && trst_eff_n) |=> usr_shift);

  // R7
  shift_exit_chk: assert property (@(posedge tck) disable iff (por)
    (usr_shift && tms && trst_eff_n) |=> (!usr_shift && !usr_update && usr_rst_n));

  // R11
  shift_drives_chk: assert property (@(posedge tck) disable iff (por)
    usr_shift |-> tdo_oe);

  // R11
  idle_floats_chk: assert property (@(posedge tck) disable iff (por)
    (usr_capture || usr_update || !usr_rst_n) |-> !tdo_oe);

  // R1
  ir_reset_code_chk: assert property (@(posedge tck) disable iff (por)
    !usr_rst_n |=> (usr_ir == '1));

endmodule

bind user_tap user_tap_chk #(.IR_W(IR_W)) u_chk (
  .tck(tck), .por(por), .tms(tms), .trst_n(trst_n), .sec_en(sec_en),
  .sec_trst_n(sec_trst_n), .usr_ir(usr_ir), .usr_rst_n(usr_rst_n),
  .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_update(usr_update),
  .tdo_oe(tdo_oe)
);

// File: tb/user_tap_bench.sv
`timescale 1ns/1ps
module user_tap_bench;

  logic       tck = 1'b0;
  logic       por = 1'b1;
  logic       tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
  logic       sec_en = 1'b0, sec_tdi = 1'b0, sec_trst_n = 1'b1;
  logic       usr_tdo = 1'b0;
  logic       tdo, tdo_oe, usr_rst_n, usr_tdi, usr_tck;
  logic       usr_capture, usr_shift, usr_update;
  logic [7:0] usr_ir;

  int n_vec = 0;
  int n_bad = 0;

  always #2 tck = ~tck;  // 250 MHz

  user_tap u_user_tap (
    .tck(tck), .por(por), .tms(tms), .tdi(tdi), .trst_n(trst_n),
    .tdo(tdo), .tdo_oe(tdo_oe), .sec_en(sec_en), .sec_tdi(sec_tdi),
    .sec_trst_n(sec_trst_n), .usr_ir(usr_ir), .usr_rst_n(usr_rst_n),
    .usr_tdi(usr_tdi), .usr_tck(usr_tck), .usr_tdo(usr_tdo),
    .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_update(usr_update)
  );

  // {tms,tdi,usr_tdo}_{capture,shift,update}_{rst_n,oe,tdo}_{ir}
  localparam int NV = 36;
  localparam logic [16:0] VEC [NV] = '{
    17'b000_000_100_11111111, // idle
    17'b100_000_100_11111111, // select data
    17'b000_100_100_11111111, // capture data
    17'b000_010_110_11111111, // shift: bypass captured 0
    17'b010_010_111_11111111, // shift in 1, seen on tdo
    17'b000_010_110_11111111, // shift in 0
    17'b110_000_100_11111111, // exit1
    17'b100_001_100_11111111, // update data
    17'b100_000_100_11111111, // select data
    17'b100_000_100_11111111, // select instruction
    17'b000_000_100_11111111, // capture instruction
    17'b000_000_111_11111111, // shift instr: captured bit0 = 1
    17'b000_000_110_11111111,
    17'b000_000_110_11111111,
    17'b000_000_110_11111111,
    17'b000_000_110_11111111,
    17'b000_000_110_11111111,
    17'b010_000_110_11111111,
    17'b000_000_110_11111111,
    17'b100_000_100_11111111, // exit1 instr (ir unchanged)
    17'b100_000_100_11111111, // update instr (ir unchanged)
    17'b000_000_100_00100000, // idle, ir = 0x20
    17'b100_000_100_00100000,
    17'b000_100_100_00100000,
    17'b001_010_111_00100000, // user tdo 1
    17'b000_010_110_00100000, // user tdo 0
    17'b101_000_100_00100000, // exit1
    17'b000_000_100_00100000, // pause
    17'b100_000_100_00100000, // exit2
    17'b001_010_111_00100000, // back to shift
    17'b100_000_100_00100000,
    17'b100_001_100_00100000,
    17'b100_000_100_00100000,
    17'b100_000_100_00100000,
    17'b100_000_000_00100000, // reset state, ir not yet reset
    17'b100_000_000_11111111  // ir reset code
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, input logic u);
    tms = m; tdi = d; usr_tdo = u;
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [7:0] code);
    repeat (5) step(1'b1, 1'b0, 1'b0);
    step(0, 0, 0); step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int b = 0; b < 8; b++) step(b == 7, code[b], 1'b0);
    step(1, 0, 0); step(0, 0, 0);
  endtask

  task automatic dr_first(input logic u, output logic out);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, u);
    out = tdo;
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] got;
    logic        o;
    logic [7:0]  codes [4];
    logic        expd  [4];
    codes[0] = 8'h10; expd[0] = 1'b1;
    codes[1] = 8'h7F; expd[1] = 1'b1;
    codes[2] = 8'h0F; expd[2] = 1'b0;
    codes[3] = 8'h80; expd[3] = 1'b0;

    @(negedge tck); #1;
    step(1, 0, 0); step(1, 0, 0);
    por = 1'b0;
    // R8 R1 R5 R11: power-on state
    got = {usr_capture, usr_shift, usr_update, usr_rst_n, tdo_oe, tdo, usr_ir};
    check(got == 14'b000_000_11111111, "R8 R1 R5 R11 reset state", got, 14'b000_000_11111111);

    // R2 R4 R5 R6 R7 R11 R1 R3: vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15], VEC[i][14]);
      got = {usr_capture, usr_shift, usr_update, usr_rst_n, tdo_oe, tdo, usr_ir};
      check(got == VEC[i][13:0], $sformatf("R1 R2 R3 R4 R5 R6 R7 R11 vector %0d", i), got, VEC[i][13:0]);
    end

    // R3 R4: user-range boundaries
    for (int k = 0; k < 4; k++) begin
      load_ir(codes[k]);
      check(usr_ir == codes[k], "R1 R2 loaded code", usr_ir, codes[k]);
      dr_first(1'b1, o);
      check(o == expd[k], expd[k] ? "R3 user range tdo" : "R4 bypass tdo", o, expd[k]);
    end

    // R7: four high steps from shift-data are not enough, five are
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    check(usr_shift == 1'b1, "R7 reached shift-data", usr_shift, 1);
    repeat (4) step(1, 0, 0);
    check(usr_rst_n == 1'b1, "R7 four high not reset", usr_rst_n, 1);
    step(1, 0, 0);
    check(usr_rst_n == 1'b0, "R7 five high reset", usr_rst_n, 0);

    // R8: external test reset overrides tms
    step(0, 0, 0);
    trst_n = 1'b0;
    step(0, 0, 0);
    check(usr_rst_n == 1'b0, "R8 trst forces reset", usr_rst_n, 0);
    step(0, 0, 0);
    check(usr_rst_n == 1'b0, "R8 trst holds reset", usr_rst_n, 0);
    trst_n = 1'b1;
    step(0, 0, 0);
    check(usr_rst_n == 1'b1, "R8 release to idle", usr_rst_n, 1);

    // R9: override path
    sec_en = 1'b1; sec_trst_n = 1'b0;
    step(0, 0, 0);
    check(usr_rst_n == 1'b0, "R9 override reset acts", usr_rst_n, 0);
    sec_trst_n = 1'b1; trst_n = 1'b0;
    step(0, 0, 0);
    check(usr_rst_n == 1'b1, "R9 external reset ignored", usr_rst_n, 1);
    tdi = 1'b0; sec_tdi = 1'b1; #0.2;
    check(usr_tdi == 1'b1, "R9 R10 override tdi", usr_tdi, 1);
    sec_en = 1'b0; trst_n = 1'b1; tdi = 1'b1; sec_tdi = 1'b0; #0.2;
    check(usr_tdi == 1'b1, "R10 external tdi", usr_tdi, 1);
    step(0, 0, 0);

    // R10: clock copy in both phases
    check(usr_tck == tck, "R10 usr_tck low phase", usr_tck, tck);
    @(posedge tck); #0.2;
    check(usr_tck == 1'b1, "R10 usr_tck high phase", usr_tck, 1);
    @(negedge tck); #1;

    // R11: tdo moves only on the falling edge
    load_ir(8'h40);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    check(tdo == 1'b0 && tdo_oe == 1'b1, "R11 shift with user bit 0", {tdo_oe, tdo}, 2'b10);
    usr_tdo = 1'b1;
    #1.5;
    check(tdo == 1'b0, "R11 held across rising edge", tdo, 0);
    #2;
    check(tdo == 1'b1, "R11 updated after falling edge", tdo, 1);
    #0.5;
    step(1, 0, 0);
    check(tdo_oe == 1'b0 && tdo == 1'b0, "R11 disabled out of shift", {tdo_oe, tdo}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule